// File: doc/BRIEF.md
# Handshaked Fall-Through FIFO Buffer

This block is a first-in/first-out buffer with 64 words and a data width of 4 or 5 bits. A write side and a read side each move data with a level strobe. The strobes are asynchronous to the system clock. Each one passes through a two-flop synchronizer and is then used as a level or as a falling edge. The write side captures a word while shift-in is high and the buffer has room. The write pointer advances when shift-in falls. The read side keeps the oldest word in an output register before any read is requested, and marks it valid with the output-ready flag. A read takes effect when shift-out goes low.

The flags follow a request/acknowledge pattern, so two buffers chain without glue logic:
- data out of the first buffer drives data in of the second;
- output-ready of the first drives shift-in of the second;
- input-ready of the second drives shift-out of the first.

When the buffer runs empty, the last word read stays on the outputs. An active-low output enable forces the outputs to zero. An active-low master reset empties the buffer and drives the outputs to zero.

Top module: `shift_fifo`

## Requirements
- R1: While rst_ni is low, in_rdy_o is 1, out_rdy_o is 0, data_o is all zeros and the stored contents are discarded.
- R2: A capture happens on the third rising clock edge after shift-in rises, provided in_rdy_o is 1. At that capture, in_rdy_o goes to 0. It returns to 1 on the third edge after shift-in falls, unless the buffer then holds 64 words.
- R3: With 64 words stored, in_rdy_o stays 0 and a shift-in pulse that ends before space is freed writes nothing.
- R4: Words leave in the order in which they were captured, with no loss and no duplication.
- R5: A word captured into an empty buffer appears on data_o with out_rdy_o at 1 one clock after its capture edge, which is the fourth edge after shift-in rises.
- R6: While out_rdy_o is 1, a high level on shift-out drops out_rdy_o on the third edge and data_o holds its word. The word is removed on the third edge after shift-out falls. The next stored word, if any, then appears one clock later with out_rdy_o at 1.
- R7: A shift-out pulse while out_rdy_o is 0 has no effect. Once the buffer is empty, the last word read stays on data_o with out_rdy_o at 0, until reset or until a new word falls through.
- R8: If shift-out is held high while the buffer is empty and a word arrives, out_rdy_o is 1 for exactly one clock. That word stays on data_o, and later words wait behind it until shift-out falls.
- R9: If shift-in is held high while the buffer is full, the waiting word is captured as soon as a removal frees a location.
- R10: If shift-in is high when rst_ni is released, the input word is written without a new rising edge, and in_rdy_o stays 0 until shift-in falls.
- R11: While oe_ni is 1, data_o is all zeros. The flags and the stored word are not affected, and the word reappears when oe_ni returns to 0.
- R12: Two instances chained head to tail deliver the words in order at the second instance's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| data_i | input | WIDTH | Write data |
| shin_i | input | 1 | Shift-in strobe, asynchronous level |
| in_rdy_o | output | 1 | Input-ready flag |
| data_o | output | WIDTH | Presented word, zero while disabled |
| shout_i | input | 1 | Shift-out strobe, asynchronous level |
| out_rdy_o | output | 1 | Output-ready flag |
| oe_ni | input | 1 | Active-low output enable |

## Verification
The assertions assume three things about the inputs:
- each level of each strobe lasts at least three clocks, so the synchronizer passes both of its edges;
- data_i is held stable while shin_i is high, until in_rdy_o has fallen;
- oe_ni changes only between samples of data_o.

The stimulus changes every input on the falling clock edge and holds each strobe level for four clocks. It drives the held-strobe cases (full buffer with shift-in held high, empty buffer with shift-out held high) as long, explicit levels rather than as pulses.

// File: rtl/sf_pkg.sv
package sf_pkg;
  parameter int unsigned SF_DEPTH = 64;

  typedef enum logic [1:0] {
    RD_IDLE,  // nothing presented
    RD_SHOW,  // head word valid on output register
    RD_HOLD   // read accepted, waiting for strobe to fall
  } sf_rd_e;
endpackage

// File: rtl/sf_strobe_sync.sv
module sf_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], strobe_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign fall_o  = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/sf_store.sv
module sf_store #(
  parameter int unsigned WIDTH = 5,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo
  import sf_pkg::*;
#(
  parameter int unsigned WIDTH       = 5,
  parameter int unsigned DEPTH       = SF_DEPTH,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shin_i,
  output logic             in_rdy_o,
  output logic [WIDTH-1:0] data_o,
  input  logic             shout_i,
  output logic             out_rdy_o,
  input  logic             oe_ni
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned NS = 2;  // 0: shift-in, 1: shift-out

  logic [NS-1:0] strb, lvl, fall;
  assign strb = {shout_i, shin_i};

  for (genvar g = 0; g < NS; g++) begin : g_sync
    sf_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .strobe_i(strb[g]),
      .level_o (lvl[g]),
      .fall_o  (fall[g])
    );
  end

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             wr_hold_q;
  sf_rd_e           rd_q;
  logic [WIDTH-1:0] out_q, rdata;
  logic             full, cap, wr_adv, accept, pop, load;

  assign full   = (cnt_q == CW'(DEPTH));
  assign in_rdy_o = ~wr_hold_q & ~full;
  // level capture lets a held strobe load as soon as room appears
  assign cap    = lvl[0] & in_rdy_o;
  assign wr_adv = fall[0] & wr_hold_q;
  assign accept = (rd_q == RD_SHOW) & lvl[1];
  assign pop    = (rd_q == RD_HOLD) & fall[1];
  assign load   = (rd_q == RD_IDLE) & (cnt_q != '0);

  sf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk_i  (clk_i),
    .we_i   (cap),
    .waddr_i(wptr_q),
    .wdata_i(data_i),
    .raddr_i(rptr_q),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q    <= '0;
      wr_hold_q <= 1'b0;
    end else begin
      if (cap)    wr_hold_q <= 1'b1;
      if (wr_adv) begin
        wr_hold_q <= 1'b0;
        wptr_q    <= ptr_inc(wptr_q);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(cap) - CW'(pop);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= '0;
      rd_q   <= RD_IDLE;
      out_q  <= '0;
    end else begin
      unique case (rd_q)
        RD_IDLE: if (load) begin
          out_q <= rdata;
          rd_q  <= RD_SHOW;
        end
        RD_SHOW: if (accept) rd_q <= RD_HOLD;
        RD_HOLD: if (pop) begin
          rptr_q <= ptr_inc(rptr_q);
          rd_q   <= RD_IDLE;
        end
        default: rd_q <= RD_IDLE;
      endcase
    end
  end

  assign out_rdy_o = (rd_q == RD_SHOW);
  assign data_o    = oe_ni ? '0 : out_q;
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
  parameter int unsigned WIDTH = 5,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_rdy_o,
  input logic             out_rdy_o,
  input logic [WIDTH-1:0] data_o,
  input logic             oe_ni,
  input logic [CW-1:0]    cnt_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (in_rdy_o && !out_rdy_o && (oe_ni || data_o == '0));
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(DEPTH));

  a_r4_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) + CW'(1)) ||
    (cnt_i + CW'(1) == $past(cnt_i)));

  a_r6_valid_has_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_rdy_o |-> (cnt_i != '0));

  a_r7_hold_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_rdy_o && !oe_ni) |=> (out_rdy_o || oe_ni || $stable(data_o)));
endmodule

bind shift_fifo sf_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_sf_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .in_rdy_o (in_rdy_o),
  .out_rdy_o(out_rdy_o),
  .data_o   (data_o),
  .oe_ni    (oe_ni),
  .cnt_i    (cnt_q)
);

// File: tb/test_shift_fifo.sv
`timescale 1ns/1ps
module test_shift_fifo;
  localparam int W = 5;
  localparam int D = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] din = '0, dout;
  logic si = 1'b0, so = 1'b0, irdy, ordy, oe_n = 1'b0;

  shift_fifo #(.WIDTH(W), .DEPTH(D)) i_shift_fifo (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din), .shin_i(si), .in_rdy_o(irdy),
    .data_o(dout), .shout_i(so), .out_rdy_o(ordy), .oe_ni(oe_n));

  // chain of two instances
  logic [W-1:0] c_din = '0, c_mid, c_dout;
  logic c_si = 1'b0, c_irdy, c_mid_rdy, c_back_rdy, c_so = 1'b0, c_ordy;

  shift_fifo #(.WIDTH(W), .DEPTH(D)) i_shift_fifo_c0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(c_din), .shin_i(c_si), .in_rdy_o(c_irdy),
    .data_o(c_mid), .shout_i(c_back_rdy), .out_rdy_o(c_mid_rdy), .oe_ni(1'b0));
  shift_fifo #(.WIDTH(W), .DEPTH(D)) i_shift_fifo_c1 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(c_mid), .shin_i(c_mid_rdy), .in_rdy_o(c_back_rdy),
    .data_o(c_dout), .shout_i(c_so), .out_rdy_o(c_ordy), .oe_ni(1'b0));

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] chain_q[$];
  logic mon_en = 1'b0;
  int pulse_cnt = 0;

  always @(negedge clk) if (mon_en && ordy) pulse_cnt++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input int sel, input logic [W-1:0] d);
    if (sel == 0) begin din = d; si = 1'b1; end
    else begin c_din = d; c_si = 1'b1; end
    cyc(4);
    if (sel == 0) si = 1'b0; else c_si = 1'b0;
    cyc(4);
  endtask

  // monitor side of the scoreboard: pop and compare against the queue head
  task automatic pop(input int sel);
    logic [W-1:0] e;
    logic [W-1:0] got;
    logic rdy;
    got = (sel == 0) ? dout : c_dout;
    rdy = (sel == 0) ? ordy : c_ordy;
    if (sel == 0) e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
    else          e = (chain_q.size() > 0) ? chain_q.pop_front() : '0;
    check(rdy === 1'b1 && got === e, (sel == 0) ? "R4 order" : "R12 chain order",
          int'({rdy, got}), int'({1'b1, e}));
    if (sel == 0) so = 1'b1; else c_so = 1'b1;
    cyc(4);
    if (sel == 0) so = 1'b0; else c_so = 1'b0;
    cyc(4);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1: reset state
    check(irdy === 1'b1 && ordy === 1'b0 && dout === '0, "R1 reset", int'({irdy, ordy, dout}), int'({2'b10, 5'h0}));
    rst_n = 1'b1;
    cyc(2);

    // R2/R5: capture and fall-through timing
    din = 5'h0A; si = 1'b1;
    cyc(3);
    check(irdy === 1'b0 && ordy === 1'b0, "R2 capture drops in_rdy", int'({irdy, ordy}), 0);
    cyc(1);
    check(ordy === 1'b1 && dout === 5'h0A, "R5 fall-through", int'({ordy, dout}), int'({1'b1, 5'h0A}));
    si = 1'b0;
    cyc(2);
    check(irdy === 1'b0, "R2 in_rdy low until fall seen", int'(irdy), 0);
    cyc(2);
    check(irdy === 1'b1, "R2 in_rdy returns", int'(irdy), 1);

    // R6: read handshake
    so = 1'b1;
    cyc(3);
    check(ordy === 1'b0 && dout === 5'h0A, "R6 accept holds word", int'({ordy, dout}), int'({1'b0, 5'h0A}));
    so = 1'b0;
    cyc(4);
    check(ordy === 1'b0 && dout === 5'h0A, "R7 last word kept when empty", int'({ordy, dout}), int'({1'b0, 5'h0A}));

    // R7: shift-out while empty ignored
    so = 1'b1; cyc(4); so = 1'b0; cyc(4);
    check(ordy === 1'b0 && dout === 5'h0A && irdy === 1'b1, "R7 empty read ignored", int'({ordy, dout}), int'({1'b0, 5'h0A}));

    // R3: fill to full, extra pulse ignored
    for (int i = 0; i < D; i++) begin
      logic [W-1:0] v;
      v = W'(i ^ (i >> 1) ^ 3);
      exp_q.push_back(v);
      push(0, v);
    end
    check(irdy === 1'b0, "R3 full blocks input", int'(irdy), 0);
    push(0, 5'h1F);
    check(irdy === 1'b0, "R3 pulse while full", int'(irdy), 0);

    // R9: shift-in held high while full
    din = 5'h15; si = 1'b1;
    cyc(6);
    check(irdy === 1'b0, "R9 waiting while full", int'(irdy), 0);
    pop(0);
    exp_q.push_back(5'h15);
    check(irdy === 1'b0, "R9 held word captured", int'(irdy), 0);
    si = 1'b0;
    cyc(4);
    check(irdy === 1'b0, "R3 full again after held capture", int'(irdy), 0);
    while (exp_q.size() > 0) pop(0);
    check(ordy === 1'b0 && irdy === 1'b1, "R4 drained, no extra word", int'({ordy, irdy}), 1);

    // R11: output enable
    exp_q.push_back(5'h11);
    push(0, 5'h11);
    oe_n = 1'b1; cyc(1);
    check(dout === '0 && ordy === 1'b1, "R11 disabled outputs zero", int'({ordy, dout}), int'({1'b1, 5'h0}));
    oe_n = 1'b0; cyc(1);
    check(dout === 5'h11, "R11 word restored", int'(dout), 'h11);
    pop(0);

    // R8: shift-out held while empty
    so = 1'b1; cyc(4);
    pulse_cnt = 0; mon_en = 1'b1;
    push(0, 5'h09);
    mon_en = 1'b0;
    check(pulse_cnt == 1, "R8 one-clock pulse", pulse_cnt, 1);
    check(dout === 5'h09 && ordy === 1'b0, "R8 word held", int'({ordy, dout}), int'({1'b0, 5'h09}));
    push(0, 5'h0C);
    check(dout === 5'h09 && ordy === 1'b0, "R8 later word queued", int'({ordy, dout}), int'({1'b0, 5'h09}));
    so = 1'b0; cyc(4);
    exp_q.push_back(5'h0C);
    pop(0);

    // R1/R10: reset with content, release with shift-in high
    push(0, 5'h01); push(0, 5'h02);
    rst_n = 1'b0; cyc(1);
    check(irdy === 1'b1 && ordy === 1'b0 && dout === '0, "R1 reset clears", int'({irdy, ordy, dout}), int'({2'b10, 5'h0}));
    din = 5'h1B; si = 1'b1; cyc(2);
    rst_n = 1'b1; cyc(5);
    check(irdy === 1'b0 && ordy === 1'b1 && dout === 5'h1B, "R10 write at release", int'({irdy, ordy, dout}), int'({2'b01, 5'h1B}));
    si = 1'b0; cyc(4);
    check(irdy === 1'b1, "R10 in_rdy after fall", int'(irdy), 1);
    exp_q.delete();
    exp_q.push_back(5'h1B);
    pop(0);

    // R12: chained pair
    for (int i = 0; i < 12; i++) begin
      logic [W-1:0] v;
      v = W'(i * 5 + 7);
      chain_q.push_back(v);
      push(1, v);
    end
    cyc(300);
    while (chain_q.size() > 0) pop(1);
    check(c_ordy === 1'b0, "R12 chain drained", int'(c_ordy), 0);

    finish_run();
  end
endmodule